// File: doc/BRIEF.md
# Write Buffer with Read Bypass

This block sits between a write-through cache and a slow memory. Every cache write is parked in a small first-in first-out queue and the cache moves on at once; the queue empties into memory, oldest entry first, whenever the memory port has nothing better to do. Read misses arrive on a separate request path and share the same single memory port.

Before a read miss reaches memory, its address is compared in parallel against every word still held in the queue. When one or more entries match, the newest matching word is handed back to the requester in the same cycle and memory is not touched. When nothing matches, the read is sent to memory ahead of all queued writes, so a read miss never waits for the queue to empty. The port carries one transaction at a time. A write that arrives while the queue is full is held off until an entry has been retired.

Top module: `wbuf_top`

## Requirements
- R1: After reset the queue is empty: `wrReady` is 1, `memReq` is 0 and `rdRespValid` is 0.
- R2: A write presented with `wrReady` high is stored at that clock edge. With DEPTH words held, `wrReady` is 0 and a presented write is not stored until an entry has been retired.
- R3: Queued writes reach memory in arrival order, one transaction each (`memWe` = 1), and an entry is retired only at the `memAck` of its own write.
- R4: A read whose address matches no queued entry is issued to memory (`memWe` = 0) at the first idle port cycle, ahead of every queued write; its response comes with `memAck`, carrying `memRData`, with `rdFromBuf` = 0.
- R5: A read whose address matches a queued entry is answered in the same cycle as the request, with the data of the newest matching entry, `rdFromBuf` = 1, and no memory transaction; this also holds while a write is in flight.
- R6: At most one memory transaction is outstanding: `memReq`, `memWe`, `memAddr` and `memWData` stay stable until `memAck`, and a new request starts only after the port has gone idle.
- R7: Every read returns the value most recently written to its address, whether it is served from the queue or from memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrValid | input | 1 | Cache write request |
| wrAddr | input | ADDR_W | Write word address |
| wrData | input | DATA_W | Write data |
| wrReady | output | 1 | Queue has room; write is taken at this edge |
| rdValid | input | 1 | Read-miss request, held until `rdRespValid` |
| rdAddr | input | ADDR_W | Read word address |
| rdRespValid | output | 1 | Read response present this cycle |
| rdData | output | DATA_W | Read response data |
| rdFromBuf | output | 1 | Response came from the queue |
| memReq | output | 1 | Memory transaction pending |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | ADDR_W | Memory word address |
| memWData | output | DATA_W | Memory write data |
| memAck | input | 1 | One-cycle completion of the pending transaction |
| memRData | input | DATA_W | Memory read data, valid with `memAck` |

## Verification
The hardest case to reach is a read that overtakes queued writes: it needs a full queue, a write already holding the port, and a read to an address absent from the queue, all at once. The bench gets there by letting its memory model withhold acknowledgements while it fills the queue, with a duplicated address so the newest-match choice is visible. It then posts a non-matching read and a fifth write against the full queue, and releases memory. The logged order of memory transactions shows the read slotted directly after the in-flight write and the remaining writes in arrival order.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;

  // Strobes from the control unit to the datapath
  typedef struct packed {
    logic push;        // store incoming write at tail
    logic pop;         // retire head entry
    logic issueRead;   // launch read miss on memory port
    logic issueWrite;  // launch head entry on memory port
    logic clearReq;    // pending transaction completed
  } wbCtl_t;

  typedef enum logic [1:0] {
    PORT_IDLE = 2'd0,
    PORT_RD   = 2'd1,
    PORT_WR   = 2'd2
  } portState_t;

endpackage

// File: rtl/wbuf_datapath.sv
module wbuf_datapath
  import wbuf_pkg::*;
#(
  parameter int DEPTH  = 4,   // power of two, at least 2
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  wbCtl_t            ctl,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              memAck,
  output logic              full,
  output logic              empty,
  output logic              fwdHit,
  output logic [DATA_W-1:0] fwdData,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWData
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [ADDR_W-1:0] addrQ [DEPTH];
  logic [DATA_W-1:0] dataQ [DEPTH];
  logic [PTR_W-1:0]  head, tail;
  logic [CNT_W-1:0]  count;
  logic [DEPTH-1:0]  hitVec;

  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);

  // Queue storage
  always_ff @(posedge clk) begin
    if (ctl.push) begin
      addrQ[tail] <= wrAddr;
      dataQ[tail] <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (ctl.push) tail <= tail + 1'b1;
      if (ctl.pop)  head <= head + 1'b1;
      count <= count + CNT_W'(ctl.push) - CNT_W'(ctl.pop);
    end
  end

  // Per-slot address compare, live slots only
  generate
    for (genvar g = 0; g < DEPTH; g++) begin : gSlot
      logic [PTR_W-1:0] age;
      assign age       = PTR_W'(g) - head;
      assign hitVec[g] = (CNT_W'(age) < count) && (addrQ[g] == rdAddr);
    end
  endgenerate

  // Walk oldest to newest so the newest hit wins
  always_comb begin
    logic [PTR_W-1:0] slot;
    fwdHit  = 1'b0;
    fwdData = '0;
    for (int k = 0; k < DEPTH; k++) begin
      slot = head + PTR_W'(k);
      if (hitVec[slot]) begin
        fwdHit  = 1'b1;
        fwdData = dataQ[slot];
      end
    end
  end

  // Memory port registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memReq   <= 1'b0;
      memWe    <= 1'b0;
      memAddr  <= '0;
      memWData <= '0;
    end else if (ctl.issueRead) begin
      memReq  <= 1'b1;
      memWe   <= 1'b0;
      memAddr <= rdAddr;
    end else if (ctl.issueWrite) begin
      memReq   <= 1'b1;
      memWe    <= 1'b1;
      memAddr  <= addrQ[head];
      memWData <= dataQ[head];
    end else if (ctl.clearReq) begin
      memReq <= 1'b0;
    end
  end

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.push |-> (count < CNT_W'(DEPTH)));

  assert_pop_live_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.pop |-> (count != '0));

  assert_port_held_R6: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe) && $stable(memWData)));

  assert_issue_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.issueRead || ctl.issueWrite) |-> !memReq);

endmodule

// File: rtl/wbuf_control.sv
module wbuf_control
  import wbuf_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   wrValid,
  input  logic   rdValid,
  input  logic   full,
  input  logic   empty,
  input  logic   fwdHit,
  input  logic   memAck,
  output wbCtl_t ctl,
  output logic   wrReady,
  output logic   rdRespValid,
  output logic   rdFromBuf
);

  portState_t state, stateNext;
  logic fwdOk;

  // Forwarding is disabled while this requester's read is at memory
  assign fwdOk   = rdValid && fwdHit && (state != PORT_RD);
  assign wrReady = !full;

  always_comb begin
    ctl            = '0;
    ctl.push       = wrValid && !full;
    ctl.issueRead  = (state == PORT_IDLE) && rdValid && !fwdHit;
    ctl.issueWrite = (state == PORT_IDLE) && !ctl.issueRead && !empty;
    ctl.clearReq   = (state != PORT_IDLE) && memAck;
    ctl.pop        = (state == PORT_WR) && memAck;
    rdRespValid    = fwdOk || ((state == PORT_RD) && memAck);
    rdFromBuf      = fwdOk;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      PORT_IDLE: if (ctl.issueRead) stateNext = PORT_RD;
                 else if (ctl.issueWrite) stateNext = PORT_WR;
      PORT_RD, PORT_WR: if (memAck) stateNext = PORT_IDLE;
      default: stateNext = PORT_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= PORT_IDLE;
    else       state <= stateNext;
  end

  assert_resp_has_req_R5: assert property (@(posedge clk) disable iff (!rstN)
    rdRespValid |-> rdValid);

  assert_read_first_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !fwdHit && state == PORT_IDLE) |=> (state == PORT_RD));

endmodule

// File: rtl/wbuf_top.sv
module wbuf_top
  import wbuf_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              wrReady,
  input  logic              rdValid,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic              rdRespValid,
  output logic [DATA_W-1:0] rdData,
  output logic              rdFromBuf,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWData,
  input  logic              memAck,
  input  logic [DATA_W-1:0] memRData
);

  wbCtl_t            ctl;
  logic              full, empty, fwdHit;
  logic [DATA_W-1:0] fwdData;

  wbuf_control u_ctrl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .rdValid(rdValid),
    .full(full), .empty(empty), .fwdHit(fwdHit), .memAck(memAck),
    .ctl(ctl), .wrReady(wrReady), .rdRespValid(rdRespValid), .rdFromBuf(rdFromBuf)
  );

  wbuf_datapath #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .memAck(memAck), .full(full), .empty(empty),
    .fwdHit(fwdHit), .fwdData(fwdData), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWData(memWData)
  );

  assign rdData = rdFromBuf ? fwdData : memRData;

endmodule

// File: tb/sim_wbuf_top.sv
`timescale 1ns/1ps
module sim_wbuf_top;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int LAT    = 2;
  localparam int NVEC   = 12;

  // {isWrite, addr, data, expectedReadData}
  localparam logic [80:0] VEC [NVEC] = '{
    {1'b1, 16'd8,  32'h1111_1111, 32'h0},
    {1'b1, 16'd9,  32'h2222_2222, 32'h0},
    {1'b0, 16'd8,  32'h0,         32'h1111_1111},
    {1'b1, 16'd8,  32'h3333_3333, 32'h0},
    {1'b0, 16'd8,  32'h0,         32'h3333_3333},
    {1'b0, 16'd10, 32'h0,         32'hA000_000A},
    {1'b1, 16'd10, 32'h4444_4444, 32'h0},
    {1'b1, 16'd11, 32'h5555_5555, 32'h0},
    {1'b1, 16'd10, 32'h6666_6666, 32'h0},
    {1'b0, 16'd10, 32'h0,         32'h6666_6666},
    {1'b0, 16'd11, 32'h0,         32'h5555_5555},
    {1'b0, 16'd9,  32'h0,         32'h2222_2222}
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrValid = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [DATA_W-1:0] wrData = '0;
  logic              wrReady;
  logic              rdValid = 1'b0;
  logic [ADDR_W-1:0] rdAddr = '0;
  logic              rdRespValid;
  logic [DATA_W-1:0] rdData;
  logic              rdFromBuf;
  logic              memReq, memWe;
  logic [ADDR_W-1:0] memAddr;
  logic [DATA_W-1:0] memWData;
  logic              memAck = 1'b0;
  logic [DATA_W-1:0] memRData = '0;

  logic [DATA_W-1:0] mem [16];
  logic [4:0]        txLog [32];
  int                logN = 0;
  int                waitCnt = 0;
  bit                memHold = 1'b0;
  int                total = 0;
  int                fails = 0;
  bit                done = 1'b0;

  always #10 clk = ~clk;

  wbuf_top u0 (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData),
    .wrReady(wrReady), .rdValid(rdValid), .rdAddr(rdAddr), .rdRespValid(rdRespValid),
    .rdData(rdData), .rdFromBuf(rdFromBuf), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWData(memWData), .memAck(memAck), .memRData(memRData)
  );

  // Slow memory model: acknowledges LAT negedges after a request, unless held
  initial for (int i = 0; i < 16; i++) mem[i] = 32'hA000_0000 + i;

  always @(negedge clk) begin
    if (memReq && !memAck && !memHold) begin
      if (waitCnt == LAT - 1) begin
        memAck  <= 1'b1;
        waitCnt <= 0;
        if (memWe) mem[memAddr[3:0]] <= memWData;
        else       memRData <= mem[memAddr[3:0]];
        if (logN < 32) begin
          txLog[logN] <= {memWe, memAddr[3:0]};
          logN <= logN + 1;
        end
      end else begin
        waitCnt <= waitCnt + 1;
      end
    end else begin
      memAck <= 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Called at a negedge; returns at a negedge
  task automatic doWrite(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    wrValid = 1'b1;
    wrAddr  = a;
    wrData  = d;
    while (!wrReady) @(negedge clk);
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  task automatic doRead(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d,
                        output logic fwd, output int lat);
    rdValid = 1'b1;
    rdAddr  = a;
    lat = 0;
    #1;
    while (!rdRespValid) begin
      @(negedge clk);
      #1;
      lat++;
    end
    d   = rdData;
    fwd = rdFromBuf;
    @(negedge clk);
    rdValid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", "run did not finish", 32'd0, 32'd1);
      $display("  %0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [DATA_W-1:0] d;
    logic              f;
    int                lat;
    int                base;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: state right after reset
    check(wrReady && !memReq && !rdRespValid, "R1", "reset outputs",
          {29'd0, wrReady, memReq, rdRespValid}, 32'h4);

    // R7: vector table, reads always see the latest written value
    for (int v = 0; v < NVEC; v++) begin
      if (VEC[v][80]) doWrite(VEC[v][79:64], VEC[v][63:32]);
      else begin
        doRead(VEC[v][79:64], d, f, lat);
        check(d == VEC[v][31:0], "R7", $sformatf("vector %0d read", v), d, VEC[v][31:0]);
      end
    end
    repeat (20) @(negedge clk);
    base = logN;

    // Fill the queue with memory stalled
    #2 memHold = 1'b1;
    @(negedge clk);
    doWrite(16'd1, 32'h1000_0001);
    doWrite(16'd2, 32'h1000_0002);
    doWrite(16'd3, 32'h1000_0003);
    doWrite(16'd1, 32'h1000_00F1);
    check(!wrReady, "R2", "full queue refuses writes", {31'd0, wrReady}, 32'd0);
    check(memReq && memWe && memAddr == 16'd1, "R6", "stalled write held on port",
          {15'd0, memReq, memAddr}, {15'd0, 1'b1, 16'd1});

    // R5: newest matching entry forwarded in the request cycle
    doRead(16'd1, d, f, lat);
    check(d == 32'h1000_00F1 && f && lat == 0, "R5", "forward newest match",
          d, 32'h1000_00F1);

    // R2: write held off while full
    wrValid = 1'b1; wrAddr = 16'd4; wrData = 32'h1000_0004;
    begin
      bit seen = 1'b0;
      for (int c = 0; c < 3; c++) begin
        @(negedge clk);
        if (wrReady) seen = 1'b1;
      end
      check(!seen, "R2", "stall while full", {31'd0, seen}, 32'd0);
    end

    // R4: non-matching read overtakes queued writes once memory resumes
    fork
      begin
        while (!wrReady) @(negedge clk);
        @(negedge clk);
        wrValid = 1'b0;
      end
      doRead(16'd7, d, f, lat);
      begin
        @(negedge clk);
        #2 memHold = 1'b0;
      end
    join
    check(d == 32'hA000_0007 && !f, "R4", "bypass read from memory", d, 32'hA000_0007);
    repeat (30) @(negedge clk);
    check(logN - base == 6 && txLog[base + 1] == 5'h07, "R4", "read second on port",
          {27'd0, txLog[base + 1]}, 32'h07);
    check(txLog[base] == 5'h11 && txLog[base + 2] == 5'h12 && txLog[base + 3] == 5'h13 &&
          txLog[base + 4] == 5'h11 && txLog[base + 5] == 5'h14, "R3", "drain order",
          {txLog[base + 2], txLog[base + 3], txLog[base + 4], txLog[base + 5], 12'd0},
          {5'h12, 5'h13, 5'h11, 5'h14, 12'd0});
    check(mem[1] == 32'h1000_00F1 && mem[4] == 32'h1000_0004, "R7", "memory after drain",
          mem[1], 32'h1000_00F1);

    // R7: read after drain is served by memory
    doRead(16'd1, d, f, lat);
    check(d == 32'h1000_00F1 && !f, "R7", "read after drain", d, 32'h1000_00F1);
    check(wrReady && !memReq, "R1", "idle after drain", {30'd0, wrReady, memReq}, 32'h2);

    done = 1'b1;
    $display("  %0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule